// File: doc/BRIEF.md
# Row Hit Pattern Timestamp Logger

This block is the digital logic behind one row of a binary-readout pixel sensor. On every beam-crossing strobe during a train, it samples the row's 42 one-shot comparator flags. Pixels flagged in a serially loaded noise mask are removed. The row is then treated as seven blocks of six neighbouring pixels. Each block that still holds a hit becomes a compact record: the crossing number, the block index and the six-bit pattern. The record goes into a local record memory.

While the train is active the block only writes. Once the train ends, the stored records leave through a valid/ready port in the order they were written. Each one carries the static row address in its upper bits. A done flag marks the end of the data, and a sticky flag reports any records lost because the memory was full. Pulsing the train-start input clears the crossing counter, the memory pointers and the loss flag for the next train.

Top module: `row_hit_logger`

## Requirements
- R1: Mask bit 1 means the pixel is masked. A masked pixel's hit flag never contributes to a record. The mask shifts one bit per cycle with `mask_shift` only while `train_active` is low, and it is frozen while the train is active. The mask moves toward higher pixel indices, so after 42 shifts the first bit shifted in sits at pixel 41 and the last bit at pixel 0.
- R2: Each output word is {row_addr[8:0], timestamp[12:0], group[2:0], pattern[5:0]}, from bit 30 down to bit 0. Group g covers pixels 6g..6g+5, and pattern bit i is pixel 6g+i.
- R3: For one crossing, exactly one record is written for each group with at least one unmasked hit. These records are written one per clock cycle in ascending group order. Crossing strobes must be at least 7 cycles apart whenever hits are present.
- R4: The timestamp is the number of accepted crossing strobes since the last `train_start`, so the first crossing is 0. The count wraps modulo 8192.
- R5: Strobes and hit flags presented while `train_active` is low produce no record and do not advance the crossing count.
- R6: `rd_valid` is only asserted while `train_active` is low. Records come out in write order, and a word is consumed on a cycle where `rd_valid` and `rd_ready` are both high.
- R7: `rd_done` is high exactly when `train_active` is low and every stored record has been consumed.
- R8: The memory holds DEPTH records (default 64). Records beyond that are dropped, and `rd_overflow` is set and stays set.
- R9: `train_start` clears the crossing count, the stored records, the read position and `rd_overflow`.
- R10: After reset, `rd_valid` is 0, `rd_overflow` is 0 and the mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_start | input | 1 | One-cycle pulse that prepares a new train |
| train_active | input | 1 | High during a train (recording), low in the gap (readout) |
| xing_strobe | input | 1 | One-cycle pulse per beam crossing |
| hit_flags | input | 42 | One-shot comparator flags, one per pixel |
| mask_shift | input | 1 | Shift enable for the noise mask |
| mask_sin | input | 1 | Serial mask data in |
| row_addr | input | 9 | Static row address prepended on readout |
| rd_ready | input | 1 | Consumer accepts the current word |
| rd_valid | output | 1 | Readout word available |
| rd_data | output | 31 | Readout word (row, timestamp, group, pattern) |
| rd_done | output | 1 | All records of the train have been read |
| rd_overflow | output | 1 | Sticky: at least one record was dropped |

## Verification
A table of single-crossing hit patterns drives the main path. The patterns are: an empty row, a lone pixel at each end of the row, a fully lit row, two whole groups far apart, and one pixel per group at a different in-group position. Together they separate a wrong group index from a wrong pattern bit, and a skipped group from a duplicate. Each pattern is preceded by a different number of empty crossings, so a timestamp that fails to count shows up as well. Directed cases then cover a mask with holes at both row ends and across a whole group, shifts attempted during a train, strobes during the gap, the 8192 wrap, and overfilling the memory.

// File: rtl/rhl_pkg.sv
package rhl_pkg;
  localparam int PIXELS   = 42;
  localparam int GRP_SIZE = 6;
  localparam int N_GROUPS = PIXELS / GRP_SIZE;
  localparam int TS_W     = 13;
  localparam int GRP_W    = $clog2(N_GROUPS);
  localparam int ROW_W    = 9;
  localparam int REC_W    = TS_W + GRP_W + GRP_SIZE;
  localparam int WORD_W   = ROW_W + REC_W;

  typedef struct packed {
    logic [TS_W-1:0]     ts;
    logic [GRP_W-1:0]    grp;
    logic [GRP_SIZE-1:0] pat;
  } rec_t;

  // Six-pixel slice belonging to group g.
  function automatic logic [GRP_SIZE-1:0] group_bits(input logic [PIXELS-1:0] v, input int g);
    return v[g*GRP_SIZE +: GRP_SIZE];
  endfunction

  // Readout word: row address above the stored record.
  function automatic logic [WORD_W-1:0] out_word(input logic [ROW_W-1:0] row, input rec_t r);
    return {row, r};
  endfunction
endpackage

// File: rtl/rhl_mask_chain.sv
module rhl_mask_chain
  import rhl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sin,
  output logic [PIXELS-1:0] mask
);
  // Bits move toward higher pixel index; the newest bit enters at pixel 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask <= '0;
    else if (shift_en) mask <= {mask[PIXELS-2:0], sin};
  end
endmodule

// File: rtl/rhl_group_scan.sv
module rhl_group_scan
  import rhl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [PIXELS-1:0] load_bits,
  input  logic [TS_W-1:0]   load_ts,
  output logic              wr_en,
  output rec_t              wr_rec
);
  logic [PIXELS-1:0]   pend;
  logic [TS_W-1:0]     ts_q;
  logic [N_GROUPS-1:0] grp_any;
  logic [GRP_W-1:0]    sel;
  logic [PIXELS-1:0]   clr_bits;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_any
    assign grp_any[g] = |pend[g*GRP_SIZE +: GRP_SIZE];
  end

  // Lowest pending group wins: scan downward so the last hit is the smallest.
  always_comb begin
    sel = '0;
    for (int g = N_GROUPS-1; g >= 0; g--)
      if (grp_any[g]) sel = GRP_W'(g);
    clr_bits = '0;
    clr_bits[int'(sel)*GRP_SIZE +: GRP_SIZE] = '1;
  end

  assign wr_en      = |grp_any;
  assign wr_rec.ts  = ts_q;
  assign wr_rec.grp = sel;
  assign wr_rec.pat = group_bits(pend, int'(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ts_q <= '0;
    end else if (clear) begin
      pend <= '0;
    end else if (load) begin
      pend <= load_bits;
      ts_q <= load_ts;
    end else if (wr_en) begin
      pend <= pend & ~clr_bits;
    end
  end

  // A new crossing may only arrive when at most the final group is still draining.
  p_one_crossing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> $countones(grp_any) <= 1);

  // Within one crossing the group index written strictly rises.
  p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && !$past(load) && !$past(clear)) |-> (wr_rec.grp > $past(wr_rec.grp)));

  // A record always carries at least one hit pixel.
  p_pattern_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_rec.pat != '0));
endmodule

// File: rtl/rhl_record_store.sv
module rhl_record_store
  import rhl_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic wr_en,
  input  rec_t wr_rec,
  input  logic rd_pop,
  output logic rd_avail,
  output rec_t rd_rec,
  output logic overflow,
  output logic wr_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(DEPTH + 1);

  logic [REC_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr;
  logic [PW-1:0]    rd_ptr;
  logic             full;
  logic             wr_take;

  assign full     = (wr_ptr == PW'(DEPTH));
  assign wr_take  = wr_en && !full && !clear;
  assign wr_drop  = wr_en && full && !clear;
  assign rd_avail = (rd_ptr != wr_ptr);
  assign rd_rec   = rec_t'(mem[AW'(rd_ptr)]);

  always_ff @(posedge clk) begin
    if (wr_take) mem[AW'(wr_ptr)] <= wr_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_take) wr_ptr   <= wr_ptr + 1'b1;
      if (wr_drop) overflow <= 1'b1;
      if (rd_pop)  rd_ptr   <= rd_ptr + 1'b1;
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !clear) |=> overflow);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |=> overflow);

  p_pop_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> rd_avail);
endmodule

// File: rtl/row_hit_logger.sv
module row_hit_logger
  import rhl_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              train_start,
  input  logic              train_active,
  input  logic              xing_strobe,
  input  logic [PIXELS-1:0] hit_flags,
  input  logic              mask_shift,
  input  logic              mask_sin,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_done,
  output logic              rd_overflow
);
  // Named internal events
  logic              xing_take;
  logic              mask_step;
  logic              rec_write;
  logic              rec_drop;
  logic              rd_pop;
  logic              rd_avail;
  logic [PIXELS-1:0] mask;
  logic [TS_W-1:0]   xing_cnt;
  rec_t              scan_rec;
  rec_t              out_rec;

  assign xing_take = xing_strobe && train_active && !train_start;
  assign mask_step = mask_shift && !train_active;

  rhl_mask_chain u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (mask_step),
    .sin      (mask_sin),
    .mask     (mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           xing_cnt <= '0;
    else if (train_start) xing_cnt <= '0;
    else if (xing_take)   xing_cnt <= xing_cnt + 1'b1;
  end

  rhl_group_scan u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (train_start),
    .load      (xing_take),
    .load_bits (hit_flags & ~mask),
    .load_ts   (xing_cnt),
    .wr_en     (rec_write),
    .wr_rec    (scan_rec)
  );

  rhl_record_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (train_start),
    .wr_en    (rec_write),
    .wr_rec   (scan_rec),
    .rd_pop   (rd_pop),
    .rd_avail (rd_avail),
    .rd_rec   (out_rec),
    .overflow (rd_overflow),
    .wr_drop  (rec_drop)
  );

  assign rd_valid = !train_active && rd_avail;
  assign rd_done  = !train_active && !rd_avail;
  assign rd_pop   = rd_valid && rd_ready;
  assign rd_data  = out_word(row_addr, out_rec);

  p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    train_active |=> $stable(mask));

  p_ts_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xing_take |=> (xing_cnt == $past(xing_cnt) + 1'b1));

  p_idle_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!train_active && !train_start) |=> $stable(xing_cnt));

  p_gap_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !train_active);

  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !rd_valid);

  p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    train_start |=> (!rd_overflow && xing_cnt == '0));
endmodule

// File: tb/sim_row_hit_logger.sv
module sim_row_hit_logger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_start = 1'b0;
  logic        train_active = 1'b0;
  logic        xing_strobe = 1'b0;
  logic [41:0] hit_flags = '0;
  logic        mask_shift = 1'b0;
  logic        mask_sin = 1'b0;
  logic [8:0]  row_addr = 9'h15A;
  logic        rd_ready = 1'b0;
  logic        rd_valid;
  logic [30:0] rd_data;
  logic        rd_done;
  logic        rd_overflow;

  always #2 clk = ~clk;

  row_hit_logger u0 (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_active(train_active),
    .xing_strobe(xing_strobe), .hit_flags(hit_flags), .mask_shift(mask_shift),
    .mask_sin(mask_sin), .row_addr(row_addr), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_done(rd_done), .rd_overflow(rd_overflow)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [30:0] got [0:127];
  int          ngot;
  logic [30:0] exp_w [0:127];
  int          nexp;
  logic [41:0] bench_mask = '0;

  localparam int NV = 6;
  localparam logic [41:0] VEC_HITS [NV] = '{
    42'h0, 42'h1, 42'h20000000000, 42'h3FFFFFFFFFF, 42'h0003F000FC0, 42'h20810204081 };
  localparam int VEC_NREC [NV] = '{0, 1, 1, 7, 2, 7};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Expected records for one crossing, built pixel by pixel.
  task automatic model_crossing(input logic [41:0] hits, input logic [12:0] ts);
    for (int g = 0; g < 7; g++) begin
      logic [5:0] p;
      for (int i = 0; i < 6; i++) p[i] = hits[g*6+i] & ~bench_mask[g*6+i];
      if (p != 0 && nexp < 128) begin
        exp_w[nexp] = {row_addr, ts, 3'(g), p};
        nexp++;
      end
    end
  endtask

  task automatic start_train();
    @(negedge clk); train_start = 1'b1; train_active = 1'b1;
    @(negedge clk); train_start = 1'b0;
    nexp = 0;
  endtask

  task automatic crossing(input logic [41:0] hits);
    @(negedge clk); xing_strobe = 1'b1; hit_flags = hits;
    @(negedge clk); xing_strobe = 1'b0; hit_flags = '0;
    repeat (7) @(negedge clk);
  endtask

  task automatic quick_strobes(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); xing_strobe = 1'b1;
    end
    @(negedge clk); xing_strobe = 1'b0;
  endtask

  task automatic drain();
    ngot = 0;
    @(negedge clk);
    rd_ready = 1'b1;
    for (int k = 0; k < 200; k++) begin
      if (rd_done) break;
      if (rd_valid && ngot < 128) begin
        got[ngot] = rd_data;
        ngot++;
      end
      @(negedge clk);
    end
    rd_ready = 1'b0;
  endtask

  task automatic load_mask(input logic [41:0] m);
    for (int p = 41; p >= 0; p--) begin
      @(negedge clk); mask_shift = 1'b1; mask_sin = m[p];
    end
    @(negedge clk); mask_shift = 1'b0;
    bench_mask = m;
  endtask

  task automatic compare(input string tag);
    check({tag, " count"}, 32'(ngot), 32'(nexp));
    for (int k = 0; k < nexp && k < ngot; k++) check(tag, {1'b0, got[k]}, {1'b0, exp_w[k]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid", 32'(rd_valid), 32'd0);
    check("R10 overflow", 32'(rd_overflow), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 done", 32'(rd_done), 32'd1);

    // R2 R3 R4: table walk, vector v preceded by v empty crossings
    for (int v = 0; v < NV; v++) begin
      start_train();
      if (v > 0) quick_strobes(v);
      crossing(VEC_HITS[v]);
      check("R6 no read in train", 32'(rd_valid), 32'd0);
      model_crossing(VEC_HITS[v], 13'(v));
      check("R3 table model count", 32'(nexp), 32'(VEC_NREC[v]));
      @(negedge clk); train_active = 1'b0;
      drain();
      compare("R2 R3 R4 table");
      check("R7 done after drain", 32'(rd_done), 32'd1);
    end

    // R3: back-to-back crossings at 7-cycle spacing, full row each
    start_train();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); xing_strobe = 1'b1; hit_flags = '1;
      @(negedge clk); xing_strobe = 1'b0; hit_flags = '0;
      repeat (5) @(negedge clk);
      model_crossing('1, 13'(c));
    end
    repeat (8) @(negedge clk);
    train_active = 1'b0;
    drain();
    compare("R3 tight spacing");

    // R1: mask pixels 0, 41 and all of group 3
    load_mask(42'h20000FC0001);
    start_train();
    // attempted shift during a train must not alter the mask
    @(negedge clk); mask_shift = 1'b1; mask_sin = 1'b1;
    repeat (3) @(negedge clk);
    mask_shift = 1'b0;
    crossing('1);
    model_crossing('1, 13'd0);
    crossing(42'h00000FC0000);
    @(negedge clk); train_active = 1'b0;
    drain();
    check("R1 masked count", 32'(ngot), 32'd6);
    compare("R1 mask");
    load_mask('0);

    // R5: strobes in the gap are ignored and do not count
    start_train();
    @(negedge clk); train_active = 1'b0;
    crossing('1);
    crossing(42'h1);
    drain();
    check("R5 gap records", 32'(ngot), 32'd0);
    @(negedge clk); train_active = 1'b1;
    crossing(42'h40);
    model_crossing(42'h40, 13'd0);
    @(negedge clk); train_active = 1'b0;
    drain();
    compare("R5 count frozen");

    // R4: wrap after 8192 crossings
    start_train();
    quick_strobes(8193);
    crossing(42'h800);
    model_crossing(42'h800, 13'd1);
    @(negedge clk); train_active = 1'b0;
    drain();
    compare("R4 wrap");

    // R8: overfill 64 entries with 70 records
    start_train();
    for (int c = 0; c < 10; c++) crossing('1);
    @(negedge clk); train_active = 1'b0;
    drain();
    check("R8 kept", 32'(ngot), 32'd64);
    check("R8 last kept", {1'b0, got[63]}, {1'b0, row_addr, 13'd9, 3'd0, 6'h3F});
    check("R8 overflow", 32'(rd_overflow), 32'd1);
    repeat (3) @(negedge clk);
    check("R8 sticky", 32'(rd_overflow), 32'd1);

    // R9: train start clears flag and storage
    start_train();
    check("R9 overflow cleared", 32'(rd_overflow), 32'd0);
    @(negedge clk); train_active = 1'b0;
    @(negedge clk);
    check("R9 empty", 32'(rd_done), 32'd1);
    check("R9 no valid", 32'(rd_valid), 32'd0);

    summary();
  end
endmodule